// File: doc/BRIEF.md
# Paged Control Register Access Decoder

This block sits between a narrow register-access port and a wide internal register file. The access port can only reach a 12-bit direct space. The register file, however, spans a 16-bit address space. To cover the gap, the top quarter of the direct space is a movable window. Any access whose address bits 11:10 are both 1 is redirected into the paged space. Its internal address is the page number from the control register joined with the low 10 address bits. All other addresses pass through unchanged, zero-extended to the internal width.

The block holds one control register of its own, at direct address 0x808. A 6-bit page number sits in bits 18:13 of this register. Two independent enable bits sit in bits 1:0 and drive the `pio_en` outputs. Software changes the page with a read-modify-write: it reads the register, replaces only the page field and writes the value back, so the enable bits keep their settings. Accesses to the control register are served inside the block and never reach the register file. Every other access appears one clock later as a registered read or write strobe, together with the 16-bit internal address and the write data.

Top module: `paged_reg_decoder`

## Requirements
- R1: Reset (synchronous, active high) clears the page number to 0, `pio_en` to 0 and all strobes and valid flags to 0. After reset, a window access maps to page 0.
- R2: An accepted access outside the window and not at 0x808 gives one strobe in the next cycle: `reg_rd` for a read, `reg_wr` for a write. `reg_addr` equals the direct address zero-extended to 16 bits. This includes the boundary addresses 0x7FF..0xBFF and the neighbour 0x809.
- R3: An accepted access with address bits 11:10 == 2'b11 gives a strobe in the next cycle with `reg_addr` = {page[5:0], addr[9:0]}.
- R4: A write to 0x808 loads the page from write-data bits 18:13 and `pio_en` from write-data bits 1:0. It produces no register-file strobe.
- R5: A read of 0x808 pulses `ctl_rvalid` for one cycle in the next cycle. `ctl_rdata` then carries the page in bits 18:13 and the enables in bits 1:0, with every other bit 0. No register-file strobe is produced.
- R6: A window access issued in the cycle right after a control write uses the newly written page.
- R7: A control write that only changes the page field leaves `pio_en` at the value carried in write-data bits 1:0. Stray ones in other write-data bits have no effect.
- R8: `reg_rd`, `reg_wr` and `ctl_rvalid` are single-cycle pulses, and at most one is high at a time. `reg_wdata` carries the write data of a forwarded write.
- R9: With page 63, window address 0xFFF maps to internal address 0xFFFF.
- R10: With `acc_valid` low, no strobe or valid flag is raised and the control register is unchanged, whatever the address, data and write flag are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Direct-space address |
| acc_wdata | input | 32 | Write data |
| reg_addr | output | 16 | Internal register address |
| reg_rd | output | 1 | Read strobe to register file |
| reg_wr | output | 1 | Write strobe to register file |
| reg_wdata | output | 32 | Write data to register file |
| ctl_rdata | output | 32 | Control register read data |
| ctl_rvalid | output | 1 | Control register read data valid |
| pio_en | output | 2 | Enable bits held in the control register |

## Verification
The bench builds the block with its default parameters: a 12-bit direct space, a 6-bit page and a 10-bit offset, giving a 16-bit internal space. At these sizes both page extremes (0 and 63) can be reached with a few control writes. So can the window edges 0xBFF, 0xC00 and 0xFFF, and the control address together with its neighbour 0x809. Back-to-back sequences exercise the case where a page change is followed at once by a window access. Idle cycles with busy address and data lines show that nothing leaks through.

// File: rtl/pgdec_pkg.sv
`timescale 1ns/1ps
package pgdec_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE   = 2'd0,
    ROUTE_DIRECT = 2'd1,
    ROUTE_PAGED  = 2'd2,
    ROUTE_CTRL   = 2'd3
  } route_e;
endpackage

// File: rtl/pgdec_route.sv
`timescale 1ns/1ps
// Classifies an access: control register, paged window, direct, or none.
module pgdec_route
  import pgdec_pkg::*;
#(
  parameter int DIR_AW = 12,
  parameter int OFF_W  = 10,
  parameter logic [DIR_AW-1:0] CTRL_ADDR = 12'h808
) (
  input  logic              valid,
  input  logic [DIR_AW-1:0] addr,
  output route_e            route
);
  localparam int SEL_W = DIR_AW - OFF_W;

  logic in_window;
  assign in_window = (addr[DIR_AW-1:OFF_W] == {SEL_W{1'b1}});

  always_comb begin
    if (!valid)                  route = ROUTE_NONE;
    else if (addr == CTRL_ADDR)  route = ROUTE_CTRL;
    else if (in_window)          route = ROUTE_PAGED;
    else                         route = ROUTE_DIRECT;
  end
endmodule

// File: rtl/pgdec_xlate.sv
`timescale 1ns/1ps
// Builds the internal address from the route, the direct address and the page.
module pgdec_xlate
  import pgdec_pkg::*;
#(
  parameter int DIR_AW = 12,
  parameter int OFF_W  = 10,
  parameter int PG_W   = 6
) (
  input  route_e                   route,
  input  logic [DIR_AW-1:0]        addr,
  input  logic [PG_W-1:0]          page,
  output logic [PG_W+OFF_W-1:0]    full_addr
);
  localparam int FULL_AW = PG_W + OFF_W;

  logic [FULL_AW-1:0] direct_ext;

  generate
    if (FULL_AW > DIR_AW) begin : g_pad
      assign direct_ext = {{(FULL_AW-DIR_AW){1'b0}}, addr};
    end else begin : g_trim
      assign direct_ext = addr[FULL_AW-1:0];
    end
  endgenerate

  assign full_addr = (route == ROUTE_PAGED) ? {page, addr[OFF_W-1:0]} : direct_ext;
endmodule

// File: rtl/pgdec_ctrl_reg.sv
`timescale 1ns/1ps
// Control register: page field plus independent enable bits.
module pgdec_ctrl_reg #(
  parameter int DW     = 32,
  parameter int PG_W   = 6,
  parameter int PG_LSB = 13,
  parameter int EN_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  output logic [PG_W-1:0] page,
  output logic [EN_W-1:0] en,
  output logic [DW-1:0]   rd_data,
  output logic            rd_vld
);
  logic [DW-1:0] image;

  always_comb begin
    image = '0;
    image[PG_LSB +: PG_W] = page;
    image[EN_W-1:0]       = en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page    <= '0;
      en      <= '0;
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= image;
      if (wr_en) begin
        page <= wdata[PG_LSB +: PG_W];
        en   <= wdata[EN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pgdec_issue.sv
`timescale 1ns/1ps
// Registered strobe, address and data stage toward the register file.
module pgdec_issue
  import pgdec_pkg::*;
#(
  parameter int FULL_AW = 16,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  route_e             route,
  input  logic               we,
  input  logic [FULL_AW-1:0] full_addr,
  input  logic [DW-1:0]      wdata,
  output logic [FULL_AW-1:0] reg_addr,
  output logic               reg_rd,
  output logic               reg_wr,
  output logic [DW-1:0]      reg_wdata
);
  logic fwd;
  assign fwd = (route == ROUTE_DIRECT) || (route == ROUTE_PAGED);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr  <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_rd <= fwd && !we;
      reg_wr <= fwd && we;
      if (fwd)       reg_addr  <= full_addr;
      if (fwd && we) reg_wdata <= wdata;
    end
  end
endmodule

// File: rtl/paged_reg_decoder.sv
`timescale 1ns/1ps
module paged_reg_decoder
  import pgdec_pkg::*;
#(
  parameter int DIR_AW = 12,
  parameter int OFF_W  = 10,
  parameter int PG_W   = 6,
  parameter int PG_LSB = 13,
  parameter int EN_W   = 2,
  parameter int DW     = 32,
  parameter logic [DIR_AW-1:0] CTRL_ADDR = 12'h808
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic                   acc_we,
  input  logic [DIR_AW-1:0]      acc_addr,
  input  logic [DW-1:0]          acc_wdata,
  output logic [PG_W+OFF_W-1:0]  reg_addr,
  output logic                   reg_rd,
  output logic                   reg_wr,
  output logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          ctl_rdata,
  output logic                   ctl_rvalid,
  output logic [EN_W-1:0]        pio_en
);
  localparam int FULL_AW = PG_W + OFF_W;

  route_e             route;
  logic [PG_W-1:0]    page;
  logic [FULL_AW-1:0] full_addr;
  logic               ctl_wr, ctl_rd;

  assign ctl_wr = (route == ROUTE_CTRL) && acc_we;
  assign ctl_rd = (route == ROUTE_CTRL) && !acc_we;

  pgdec_route #(.DIR_AW(DIR_AW), .OFF_W(OFF_W), .CTRL_ADDR(CTRL_ADDR)) u_route (
    .valid (acc_valid),
    .addr  (acc_addr),
    .route (route)
  );

  pgdec_ctrl_reg #(.DW(DW), .PG_W(PG_W), .PG_LSB(PG_LSB), .EN_W(EN_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctl_wr),
    .rd_en   (ctl_rd),
    .wdata   (acc_wdata),
    .page    (page),
    .en      (pio_en),
    .rd_data (ctl_rdata),
    .rd_vld  (ctl_rvalid)
  );

  pgdec_xlate #(.DIR_AW(DIR_AW), .OFF_W(OFF_W), .PG_W(PG_W)) u_xlate (
    .route     (route),
    .addr      (acc_addr),
    .page      (page),
    .full_addr (full_addr)
  );

  pgdec_issue #(.FULL_AW(FULL_AW), .DW(DW)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .route     (route),
    .we        (acc_we),
    .full_addr (full_addr),
    .wdata     (acc_wdata),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata)
  );
endmodule

// File: rtl/paged_reg_decoder_chk.sv
`timescale 1ns/1ps
module paged_reg_decoder_chk #(
  parameter int DIR_AW = 12,
  parameter int OFF_W  = 10,
  parameter int PG_W   = 6,
  parameter int PG_LSB = 13,
  parameter int EN_W   = 2,
  parameter int DW     = 32,
  parameter logic [DIR_AW-1:0] CTRL_ADDR = 12'h808
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  acc_valid,
  input logic                  acc_we,
  input logic [DIR_AW-1:0]     acc_addr,
  input logic [DW-1:0]         acc_wdata,
  input logic [PG_W+OFF_W-1:0] reg_addr,
  input logic                  reg_rd,
  input logic                  reg_wr,
  input logic [DW-1:0]         reg_wdata,
  input logic [DW-1:0]         ctl_rdata,
  input logic                  ctl_rvalid,
  input logic [EN_W-1:0]       pio_en
);
  localparam int FULL_AW = PG_W + OFF_W;
  localparam int SEL_W   = DIR_AW - OFF_W;

  logic is_ctrl, is_win, is_direct;
  logic [DW-1:0] field_mask;
  logic rst_q;

  assign is_ctrl   = acc_valid && (acc_addr == CTRL_ADDR);
  assign is_win    = acc_valid && !is_ctrl && (acc_addr[DIR_AW-1:OFF_W] == {SEL_W{1'b1}});
  assign is_direct = acc_valid && !is_ctrl && !is_win;

  always_comb begin
    field_mask = '0;
    field_mask[PG_LSB +: PG_W] = {PG_W{1'b1}};
    field_mask[EN_W-1:0]       = {EN_W{1'b1}};
  end

  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs are cleared by reset
  always @(posedge clk) begin
    if (rst_q) begin
      a_r1_reset_clear: assert (!reg_rd && !reg_wr && !ctl_rvalid && pio_en == '0);
    end
  end

  a_r2_direct_addr: assert property (@(posedge clk) disable iff (rst)
    is_direct |=> (reg_addr == FULL_AW'($past(acc_addr))) && (reg_rd != reg_wr));

  a_r3_paged_low: assert property (@(posedge clk) disable iff (rst)
    is_win |=> (reg_addr[OFF_W-1:0] == $past(acc_addr[OFF_W-1:0])) && (reg_rd || reg_wr));

  a_r4_ctl_quiet: assert property (@(posedge clk) disable iff (rst)
    is_ctrl |=> !reg_rd && !reg_wr);

  a_r4_en_load: assert property (@(posedge clk) disable iff (rst)
    (is_ctrl && acc_we) |=> pio_en == $past(acc_wdata[EN_W-1:0]));

  a_r5_rdata_clean: assert property (@(posedge clk) disable iff (rst)
    ctl_rvalid |-> (ctl_rdata & ~field_mask) == '0);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_rd, reg_wr, ctl_rvalid}) <= 1);

  a_r8_wdata: assert property (@(posedge clk) disable iff (rst)
    ((is_direct || is_win) && acc_we) |=> reg_wdata == $past(acc_wdata));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !reg_rd && !reg_wr && !ctl_rvalid && $stable(pio_en));
endmodule

bind paged_reg_decoder paged_reg_decoder_chk #(
  .DIR_AW(DIR_AW), .OFF_W(OFF_W), .PG_W(PG_W), .PG_LSB(PG_LSB),
  .EN_W(EN_W), .DW(DW), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .reg_addr(reg_addr),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid), .pio_en(pio_en)
);

// File: tb/paged_reg_decoder_bench.sv
`timescale 1ns/1ps
module paged_reg_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_we;
  logic [11:0] acc_addr;
  logic [31:0] acc_wdata;
  logic [15:0] reg_addr;
  logic        reg_rd, reg_wr, ctl_rvalid;
  logic [31:0] reg_wdata, ctl_rdata;
  logic [1:0]  pio_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  paged_reg_decoder u_paged_reg_decoder (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid), .pio_en(pio_en)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [2:0]  exp;    // {ctl_rvalid, reg_wr, reg_rd}
    logic [15:0] eaddr;
    logic [31:0] edata;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b0, 12'h123, 32'h0,         3'b001, 16'h0123, 32'h0},         // R2 direct read
    '{4'd2, 1'b1, 12'hBFF, 32'hA5A5_0001, 3'b010, 16'h0BFF, 32'hA5A5_0001}, // R2 last direct
    '{4'd3, 1'b0, 12'hC00, 32'h0,         3'b001, 16'h0000, 32'h0},         // R3 page 0
    '{4'd4, 1'b1, 12'h808, 32'h0000_A003, 3'b000, 16'h0,    32'h0},         // R4 page 5, en 11
    '{4'd5, 1'b0, 12'h808, 32'h0,         3'b100, 16'h0,    32'h0000_A003}, // R5 readback
    '{4'd3, 1'b1, 12'hC10, 32'h0000_0077, 3'b010, 16'h1410, 32'h0000_0077}, // R3 page 5
    '{4'd7, 1'b1, 12'h808, 32'hFFFF_FFFF, 3'b000, 16'h0,    32'h0},         // R7 stray ones
    '{4'd5, 1'b0, 12'h808, 32'h0,         3'b100, 16'h0,    32'h0007_E003}, // R5 page 63
    '{4'd9, 1'b0, 12'hFFF, 32'h0,         3'b001, 16'hFFFF, 32'h0},         // R9 top corner
    '{4'd2, 1'b0, 12'h809, 32'h0,         3'b001, 16'h0809, 32'h0}          // R2 neighbour
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic we, input logic [11:0] a, input logic [31:0] d);
    acc_valid = v; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_valid = 0; acc_we = 0; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 strobes", {29'b0, ctl_rvalid, reg_wr, reg_rd}, 32'h0);
    check("R1 pio_en", {30'b0, pio_en}, 32'h0);
    drive(1'b1, 1'b0, 12'h808, 32'h0);
    check("R1 page after reset", ctl_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].we, VEC[i].addr, VEC[i].wdata);
      check($sformatf("R%0d vec%0d strobes", VEC[i].req, i),
            {29'b0, ctl_rvalid, reg_wr, reg_rd}, {29'b0, VEC[i].exp});
      if (VEC[i].exp[1:0] != 2'b00)
        check($sformatf("R%0d vec%0d reg_addr", VEC[i].req, i), {16'b0, reg_addr}, {16'b0, VEC[i].eaddr});
      if (VEC[i].exp[1])
        check($sformatf("R8 vec%0d reg_wdata", i), reg_wdata, VEC[i].edata);
      if (VEC[i].exp[2])
        check($sformatf("R%0d vec%0d ctl_rdata", VEC[i].req, i), ctl_rdata, VEC[i].edata);
    end

    // R7: enables survive a page change that rewrites them unchanged
    check("R7 pio_en after stray write", {30'b0, pio_en}, 32'h3);
    drive(1'b1, 1'b1, 12'h808, 32'h0000_4002);
    check("R4 pio_en load", {30'b0, pio_en}, 32'h2);

    // R6: window access right after a page change uses the new page
    drive(1'b1, 1'b1, 12'h808, 32'h0000_E002);
    drive(1'b1, 1'b0, 12'hC05, 32'h0);
    check("R6 new page addr", {16'b0, reg_addr}, 32'h0000_1C05);
    check("R6 read strobe", {31'b0, reg_rd}, 32'h1);

    // R10 and R8: idle cycle with busy lines
    drive(1'b0, 1'b1, 12'h808, 32'h0);
    check("R8/R10 no strobe when idle", {29'b0, ctl_rvalid, reg_wr, reg_rd}, 32'h0);
    drive(1'b0, 1'b1, 12'hC00, 32'hFFFF_FFFF);
    check("R10 no strobe on idle window", {29'b0, ctl_rvalid, reg_wr, reg_rd}, 32'h0);
    drive(1'b1, 1'b0, 12'h808, 32'h0);
    check("R10 ctrl unchanged", ctl_rdata, 32'h0000_E002);

    // R1: reset mid-run returns page to 0
    rst = 1'b1; acc_valid = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 1'b0, 12'hC33, 32'h0);
    check("R1 page 0 after reset", {16'b0, reg_addr}, 32'h0000_0033);
    check("R1 pio_en cleared", {30'b0, pio_en}, 32'h0);
    drive(1'b0, 1'b0, 12'h0, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule